// File: doc/BRIEF.md
# Maskable Multi-Source Interrupt Controller

This block gathers interrupt events from six sources: an external pin, an analog comparator, a PWM/timer, and three TRIAC-driver events (falling edge, rising edge, pulse). Each event is latched into its own pending flag. An 8-bit configuration register holds a mask bit for each source, the trigger polarity of the external pin and a brown-out enable. The brown-out enable is only passed out of the block.

Unmasked pending flags are ORed into a global pending signal. Two independent global enables gate that signal: one set and cleared by the main program, the other by macro code. A request is raised only when both enables are on. The request carries the index of the highest-priority unmasked pending source. The service side writes that index back with a one-cycle acknowledge, and the acknowledge clears the flag.

The external pin goes through a two-flop synchronizer. Its active edge is then detected with the polarity taken from the configuration register.

Top module: `mask_irq_ctrl`

## Requirements
- R1: After reset the configuration register is 8'h00. Both global enables are off, no flag is pending, `irq_req` and `glob_pend` are 0, `irq_idx` is 0 and `brownout_en` is 0.
- R2: Configuration bits 0..5 are the masks for source indices 0..5, where 1 lets the source through and 0 blocks it. An event on a masked source still sets its `pend_q` bit. That bit is kept and becomes a request as soon as the mask bit is set to 1.
- R3: Source index 0 is the external pin. When configuration bit 6 is 0 its rising edge sets pending, and when bit 6 is 1 its falling edge does. The pending bit is visible after the third rising clock edge following the pin change. The opposite edge never sets it.
- R4: `glob_pend` is 1 exactly when at least one pending source has its mask bit set to 1.
- R5: `irq_req` is 1 only when `glob_pend` is 1 and both the user enable and the macro enable are on.
- R6: Each enable has its own set and clear input, and the two enables never affect each other. If set and clear are asserted together, clear wins.
- R7: The fixed priority is index 0 (external) highest, then 1 (comparator), 2 (PWM/timer), 3 (TRIAC falling), 4 (TRIAC rising) and 5 (TRIAC pulse) lowest. `irq_idx` gives the winning index while `irq_req` is 1, and 0 otherwise.
- R8: A cycle with `ack_valid` high clears the pending bit whose index equals `ack_idx`. A new event on that source in the same cycle keeps the bit set. An acknowledge with an index of 6 or 7 has no effect.
- R9: `brownout_en` follows configuration bit 7 from the cycle after the write, and that bit has no effect on pending, `glob_pend` or `irq_req`.
- R10: Writing 8'h06 lets through the comparator (index 1) and the PWM/timer (index 2) and nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| user_en_set | input | 1 | Turn the user global enable on |
| user_en_clr | input | 1 | Turn the user global enable off |
| macro_en_set | input | 1 | Turn the macro global enable on |
| macro_en_clr | input | 1 | Turn the macro global enable off |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| src_evt | input | 5 | Synchronous event pulses; bit k drives source index k+1 |
| ack_valid | input | 1 | One-cycle acknowledge |
| ack_idx | input | 3 | Source index being acknowledged |
| pend_q | output | 6 | Pending flags by source index |
| glob_pend | output | 1 | Some unmasked source is pending |
| irq_req | output | 1 | Global interrupt request |
| irq_idx | output | 3 | Index of the winning source |
| brownout_en | output | 1 | Brown-out enable from configuration bit 7 |

## Verification
An acknowledge and a fresh event can hit the same pending flag in the same cycle. The bench provokes this by driving `ack_valid` with the comparator's index while it pulses the comparator event. The flag must still read 1 afterwards, and a later lone acknowledge must clear it. A set and a clear of the same global enable are also driven together in one cycle. That case is judged by `irq_req` staying low while an unmasked source is pending and the other enable is on.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned SRC_N  = 6;
   localparam int unsigned SRC_IW = 3;
   localparam int unsigned CFG_W  = 8;
   localparam int unsigned POL_BIT = 6;
   localparam int unsigned BO_BIT  = 7;

   typedef enum logic [SRC_IW-1:0] {
      SRC_EXT    = 3'd0,
      SRC_CMP    = 3'd1,
      SRC_PWM    = 3'd2,
      SRC_TFALL  = 3'd3,
      SRC_TRISE  = 3'd4,
      SRC_TPULSE = 3'd5
   } src_e;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
   parameter int unsigned SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_o
);
   logic sync_lvl;
   logic lvl_d;

   generate
      if (SYNC_N > 4) begin : g_bad_depth
         $error("irqc_edge_sync: SYNC_N must be 0..4");
      end
      if (SYNC_N == 0) begin : g_direct
         assign sync_lvl = pin;
      end else begin : g_chain
         logic [SYNC_N-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '0;
            end else begin
               stg[0] <= pin;
               for (int k = 1; k < int'(SYNC_N); k++) stg[k] <= stg[k-1];
            end
         end
         assign sync_lvl = stg[SYNC_N-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= sync_lvl;
   end

   assign edge_o = fall_sel ? (lvl_d & ~sync_lvl) : (sync_lvl & ~lvl_d);

   AST_EDGE_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_o && !fall_sel) |=> lvl_d) else $error("rising edge not followed by high level"); // R3
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic          ack_v,
   input  logic [IW-1:0] ack_idx,
   output logic [N-1:0]  pend_o
);
   generate
      if (N > (1 << IW)) begin : g_bad_width
         $error("irqc_pend_bank: IW too narrow for N");
      end
      for (genvar g = 0; g < int'(N); g++) begin : g_src
         logic hit;
         assign hit = ack_v && (ack_idx == IW'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend_o[g] <= 1'b0;
            else if (set_i[g])   pend_o[g] <= 1'b1;
            else if (hit)        pend_o[g] <= 1'b0;
         end

         AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]) else $error("event lost"); // R2
         AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[g] && !hit) |=> pend_o[g]) else $error("pending dropped"); // R8
         AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !set_i[g]) |=> !pend_o[g]) else $error("ack did not clear"); // R8
      end
   endgenerate
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int k = int'(N) - 1; k >= 0; k--) begin
         if (req_i[k]) idx_o = IW'(k);
      end
   end

   assign any_o = |req_i;

   always_comb begin
      if (any_o) begin
         AST_WIN_IS_REQ: assert (req_i[idx_o]) else $error("winner not requesting"); // R7
         AST_NO_HIGHER: assert ((req_i & ((N'(1) << idx_o) - N'(1))) == '0)
            else $error("higher priority skipped"); // R7
      end
   end
endmodule

// File: rtl/irqc_glob_en.sv
module irqc_glob_en (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] set_v,
   input  logic [1:0] clr_v,
   output logic [1:0] en_q,
   output logic       both_o
);
   generate
      for (genvar g = 0; g < 2; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        en_q[g] <= 1'b0;
            else if (clr_v[g]) en_q[g] <= 1'b0;
            else if (set_v[g]) en_q[g] <= 1'b1;
         end

         AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_v[g] |=> !en_q[g]) else $error("clear lost"); // R6
         AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[g] && !clr_v[g]) |=> en_q[g]) else $error("set lost"); // R6
         AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_v[g] && !clr_v[g]) |=> $stable(en_q[g])) else $error("enable moved"); // R6
      end
   endgenerate

   assign both_o = &en_q;
endmodule

// File: rtl/mask_irq_ctrl.sv
module mask_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned N      = SRC_N,
   parameter int unsigned IW     = SRC_IW,
   parameter int unsigned SYNC_N = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [7:0]    cfg_wdata,
   input  logic          user_en_set,
   input  logic          user_en_clr,
   input  logic          macro_en_set,
   input  logic          macro_en_clr,
   input  logic          ext_pin,
   input  logic [N-2:0]  src_evt,
   input  logic          ack_valid,
   input  logic [IW-1:0] ack_idx,
   output logic [N-1:0]  pend_q,
   output logic          glob_pend,
   output logic          irq_req,
   output logic [IW-1:0] irq_idx,
   output logic          brownout_en
);
   localparam int unsigned CW = N + 2;

   generate
      if (CW != CFG_W) begin : g_bad_layout
         $error("mask_irq_ctrl: mask layout needs N+2 == 8");
      end
   endgenerate

   logic [CW-1:0] cfg_q;
   logic          ext_edge;
   logic [N-1:0]  set_vec;
   logic [N-1:0]  live;
   logic [IW-1:0] win_idx;
   logic [1:0]    en_q;
   logic          en_both;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   irqc_edge_sync #(.SYNC_N(SYNC_N)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (cfg_q[POL_BIT]),
      .edge_o   (ext_edge)
   );

   assign set_vec = {src_evt, ext_edge};

   irqc_pend_bank #(.N(N), .IW(IW)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .ack_v   (ack_valid),
      .ack_idx (ack_idx),
      .pend_o  (pend_q)
   );

   assign live = pend_q & cfg_q[N-1:0];

   irqc_prio_pick #(.N(N), .IW(IW)) u_prio (
      .req_i (live),
      .any_o (glob_pend),
      .idx_o (win_idx)
   );

   irqc_glob_en u_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_v  ({macro_en_set, user_en_set}),
      .clr_v  ({macro_en_clr, user_en_clr}),
      .en_q   (en_q),
      .both_o (en_both)
   );

   assign irq_req     = glob_pend & en_both;
   assign irq_idx     = irq_req ? win_idx : '0;
   assign brownout_en = cfg_q[BO_BIT];

   AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (en_q[0] && en_q[1])) else $error("request without both enables"); // R5
   AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (cfg_q[irq_idx] && pend_q[irq_idx])) else $error("masked winner"); // R2
   AST_BO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (brownout_en == $past(cfg_wdata[7]))) else $error("brown-out bit wrong"); // R9
endmodule

// File: tb/sim_mask_irq_ctrl.sv
`timescale 1ns/1ps
module sim_mask_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_we;
   logic [7:0] cfg_wdata;
   logic       user_en_set, user_en_clr, macro_en_set, macro_en_clr;
   logic       ext_pin;
   logic [4:0] src_evt;
   logic       ack_valid;
   logic [2:0] ack_idx;
   logic [5:0] pend_q;
   logic       glob_pend, irq_req, brownout_en;
   logic [2:0] irq_idx;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   mask_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .user_en_set(user_en_set), .user_en_clr(user_en_clr),
      .macro_en_set(macro_en_set), .macro_en_clr(macro_en_clr),
      .ext_pin(ext_pin), .src_evt(src_evt), .ack_valid(ack_valid), .ack_idx(ack_idx),
      .pend_q(pend_q), .glob_pend(glob_pend), .irq_req(irq_req), .irq_idx(irq_idx),
      .brownout_en(brownout_en)
   );

   // fields: cfg[19:12] ue[11] me[10] evt[9:5] gp[4] req[3] idx[2:0]
   localparam logic [19:0] VEC [7] = '{
      {8'h06, 1'b1, 1'b1, 5'b00011, 1'b1, 1'b1, 3'd1},
      {8'h06, 1'b1, 1'b1, 5'b11100, 1'b0, 1'b0, 3'd0},
      {8'h3E, 1'b1, 1'b0, 5'b10000, 1'b1, 1'b0, 3'd0},
      {8'h3E, 1'b0, 1'b1, 5'b10000, 1'b1, 1'b0, 3'd0},
      {8'h3E, 1'b1, 1'b1, 5'b11000, 1'b1, 1'b1, 3'd4},
      {8'hBE, 1'b1, 1'b1, 5'b00100, 1'b1, 1'b1, 3'd3},
      {8'h20, 1'b1, 1'b1, 5'b00110, 1'b0, 1'b0, 3'd0}
   };

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_we = 1'b1; cfg_wdata = v; tick(); cfg_we = 1'b0;
   endtask

   task automatic set_en(input logic ue, input logic me);
      user_en_set = ue; user_en_clr = !ue; macro_en_set = me; macro_en_clr = !me;
      tick();
      user_en_set = 0; user_en_clr = 0; macro_en_set = 0; macro_en_clr = 0;
   endtask

   task automatic pulse_evt(input logic [4:0] e);
      src_evt = e; tick(); src_evt = '0;
   endtask

   task automatic ack(input logic [2:0] i);
      ack_valid = 1'b1; ack_idx = i; tick(); ack_valid = 1'b0;
   endtask

   task automatic clear_all();
      for (int i = 0; i < 6; i++) ack(3'(i));
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      #(8 * 200000);
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; cfg_we = 0; cfg_wdata = 0; ext_pin = 0; src_evt = 0;
      ack_valid = 0; ack_idx = 0;
      user_en_set = 0; user_en_clr = 0; macro_en_set = 0; macro_en_clr = 0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      check("R1 pend", pend_q, 0);
      check("R1 gp", glob_pend, 0);
      check("R1 req", irq_req, 0);
      check("R1 idx", irq_idx, 0);
      check("R1 bo", brownout_en, 0);

      // R2: masked event kept pending, then unmasked
      set_en(1, 1);
      pulse_evt(5'b00001);
      check("R2 kept", pend_q, 6'b000010);
      check("R2 masked gp", glob_pend, 0);
      write_cfg(8'h02);
      check("R2 unmasked req", irq_req, 1);
      check("R2 unmasked idx", irq_idx, 1);
      clear_all();

      // table walk: R4 R5 R7 R9 R10
      for (int v = 0; v < 7; v++) begin
         write_cfg(VEC[v][19:12]);
         set_en(VEC[v][11], VEC[v][10]);
         pulse_evt(VEC[v][9:5]);
         check($sformatf("R2 pend v%0d", v), pend_q, {VEC[v][9:5], 1'b0});
         check($sformatf("R4 gp v%0d", v), glob_pend, VEC[v][4]);
         check($sformatf("R5 req v%0d", v), irq_req, VEC[v][3]);
         check($sformatf("R7 idx v%0d", v), irq_idx, VEC[v][2:0]);
         check($sformatf("R9 bo v%0d", v), brownout_en, VEC[v][19]);
         clear_all();
      end

      // R3 rising edge
      write_cfg(8'h01);
      set_en(1, 1);
      ext_pin = 1; tick(); tick();
      check("R3 rise early", pend_q[0], 0);
      tick();
      check("R3 rise pend", pend_q[0], 1);
      check("R3 rise req", irq_req, 1);
      check("R3 rise idx", irq_idx, 0);
      ack(3'd0);
      check("R8 ack ext", pend_q[0], 0);
      ext_pin = 0; repeat (4) tick();
      check("R3 fall ignored", pend_q[0], 0);

      // R3 falling edge
      write_cfg(8'h41);
      ext_pin = 1; repeat (4) tick();
      check("R3 rise ignored", pend_q[0], 0);
      ext_pin = 0; tick(); tick();
      check("R3 fall early", pend_q[0], 0);
      tick();
      check("R3 fall pend", pend_q[0], 1);
      check("R3 fall req", irq_req, 1);
      clear_all();

      // R7 external beats comparator
      write_cfg(8'h03);
      pulse_evt(5'b00001);
      check("R7 cmp alone", irq_idx, 1);
      ext_pin = 1; repeat (3) tick();
      check("R7 both pend", pend_q, 6'b000011);
      check("R7 ext wins", irq_idx, 0);
      clear_all();

      // R8 ack and event together
      write_cfg(8'h02);
      pulse_evt(5'b00001);
      src_evt = 5'b00001; ack_valid = 1; ack_idx = 3'd1; tick();
      src_evt = 0; ack_valid = 0;
      check("R8 collide keeps", pend_q[1], 1);
      ack(3'd6);
      check("R8 idx6 no effect", pend_q, 6'b000010);
      ack(3'd1);
      check("R8 ack clears", pend_q[1], 0);

      // R6 enables
      pulse_evt(5'b00001);
      check("R6 base req", irq_req, 1);
      user_en_set = 1; user_en_clr = 1; tick(); user_en_set = 0; user_en_clr = 0;
      check("R6 clr wins", irq_req, 0);
      check("R6 gp stays", glob_pend, 1);
      user_en_set = 1; tick(); user_en_set = 0;
      check("R6 user set", irq_req, 1);
      macro_en_clr = 1; tick(); macro_en_clr = 0;
      check("R6 macro clr", irq_req, 0);
      macro_en_set = 1; tick(); macro_en_set = 0;
      check("R6 macro set", irq_req, 1);
      clear_all();

      // R9 brown-out bit has no interrupt effect
      write_cfg(8'h80);
      pulse_evt(5'b11111);
      check("R9 bo out", brownout_en, 1);
      check("R9 gp", glob_pend, 0);
      check("R9 req", irq_req, 0);
      check("R10 none from 0x80", pend_q, 6'b111110);
      clear_all();

      summary();
      $finish;
   end
endmodule